// File: doc/BRIEF.md
# Frame-Sync SPI Master Transmitter

This block sends parallel words out as SPI master packets. A host writes a word into a one-word holding register. When the serial side is free, the word moves into a shift register and a packet begins. During the packet the block drives an active-low select line, a gated serial clock and a data line. A ready flag tells the host when the holding register can take the next word, so words can stream one after another with only a short select-high gap between packets.

Configuration inputs set the following, and the block samples them at the start of each packet:
- the word length, from a fixed set of six sizes;
- the idle level of the clock;
- a one-period lead between select assertion and the first data bit;
- least-significant-bit-first ordering, which is honoured only for 8-bit words.

The serial clock period is a parameter, in system clock cycles. Data changes on the clock edge that leaves the idle level. The slave samples on the edge that returns the clock to idle. With idle-high polarity, the slave therefore captures on rising edges.

Top module: `fsync_spi_tx`

## Requirements
- R1: `cfg_len` selects the number of bits per packet: code 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and codes 5, 6 and 7 give 32. The packet carries bits [L-1:0] of the written word.
- R2: Bits go out most significant first. The exception is `cfg_lsb_first`=1 together with code 0, which sends bit 0 first. For any other length, `cfg_lsb_first` has no effect.
- R3: `cs_n` is low for exactly LEAD + L*CLK_DIV cycles per packet. LEAD is 0 or CLK_DIV. `cs_n` rises half a clock period after the last capture edge.
- R4: With `cfg_dly`=0, the first launch edge occurs in the same cycle that `cs_n` falls. With `cfg_dly`=1, it occurs CLK_DIV cycles later, and `sclk` rests at idle until then.
- R5: `sclk` changes only while `cs_n` is low. While `cs_n` is high, `sclk` equals `cfg_cpol`. Inside a packet, `sdo` changes only on launch edges, where `sclk` leaves the idle level.
- R6: Inside a packet, every `sclk` level lasts CLK_DIV/2 cycles.
- R7: An accepted write drops `tx_ready` in the next cycle. If the block is idle, `cs_n` falls one cycle after the write. `tx_ready` is high again in the cycle `cs_n` falls.
- R8: If a word is already waiting when a packet ends, `cs_n` stays high for exactly CLK_DIV cycles before the next packet.
- R9: A write while `tx_ready` is low is ignored and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed; a write and a clear in the same cycle leave it set.
- R10: While `rst` is high, the block drops any word in flight. It holds `cs_n` high, `sdo` low, `sclk` at `cfg_cpol`, `tx_ready` high and `overrun` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host word, right-aligned |
| cfg_len | input | 3 | Word length code |
| cfg_lsb_first | input | 1 | Bit 0 first, for 8-bit words only |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_dly | input | 1 | One-period lead before the first bit |
| ovr_clr | input | 1 | Clears the overrun flag |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data |
| cs_n | output | 1 | Active-low select, frame sync |
| tx_ready | output | 1 | Holding register empty |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The host-side flags are due one cycle after the write edge: `tx_ready` falls and `overrun` sets then. `cs_n` falls and `tx_ready` returns one cycle after that. Serial-side results are due at fixed distances from the `cs_n` fall:
- the first launch edge, 0 or CLK_DIV cycles later;
- each clock level, CLK_DIV/2 cycles long;
- the select rise, LEAD + L*CLK_DIV cycles later.

A bench monitor samples every output at the falling system-clock edge and timestamps each event. The bench then compares the time differences, the bit count and the assembled word against values computed from the configuration alone. Flags are checked at the exact falling edge after the edge where they are due.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_BIT, ST_GAP} seq_state_t;

  // length code to bit count: 8,12,16,20,24 then 32 for the rest
  function automatic logic [CNT_W-1:0] len_from_code(input logic [2:0] code);
    case (code)
      3'd0:    len_from_code = 6'd8;
      3'd1:    len_from_code = 6'd12;
      3'd2:    len_from_code = 6'd16;
      3'd3:    len_from_code = 6'd20;
      3'd4:    len_from_code = 6'd24;
      default: len_from_code = 6'd32;
    endcase
  endfunction

  // left-align the word so the first bit to send sits in the top position
  function automatic logic [WORD_W-1:0] align_frame(input logic [WORD_W-1:0] d,
                                                    input logic [CNT_W-1:0] nbits,
                                                    input logic lsb8);
    logic [WORD_W-1:0] r;
    r = '0;
    if (lsb8) begin
      for (int i = 0; i < 8; i++) r[WORD_W-1-i] = d[i];
    end else begin
      r = d << (WORD_W - int'(nbits));
    end
    return r;
  endfunction
endpackage

// File: rtl/fstx_baud.sv
module fstx_baud #(
  parameter int HALF = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic half_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  generate
    if (HALF == 1) begin : g_direct
      assign half_tick = run;
    end else begin : g_count
      logic [CW-1:0] cnt;
      assign half_tick = run && (cnt == CW'(HALF - 1));
      always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (half_tick) cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/fstx_hold.sv
module fstx_hold
  import fstx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  input  logic              ovr_clr,
  output logic [WORD_W-1:0] hold_data,
  output logic              hold_full,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (take) hold_full <= 1'b0;
      if (wr_en && !hold_full) begin
        hold_data <= wr_data;
        hold_full <= 1'b1;
      end
      if (wr_en && hold_full) overrun <= 1'b1;
      else if (ovr_clr)       overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/fstx_seq.sv
module fstx_seq
  import fstx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_len,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_dly,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_data,
  input  logic              half_tick,
  output logic              pkt_start,
  output logic              run,
  output logic              sclk,
  output logic              sdo,
  output logic              cs_n
);
  seq_state_t        state;
  logic              phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [CNT_W-1:0]  len_q;
  logic              cpol_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  len_now;
  logic [WORD_W-1:0] frame;
  logic              gap_done;
  logic              last_bit;

  assign len_now   = len_from_code(cfg_len);
  assign frame     = align_frame(hold_data, len_now, cfg_lsb_first && (cfg_len == 3'd0));
  assign gap_done  = (state == ST_GAP) && phase && half_tick;
  assign pkt_start = hold_full && ((state == ST_IDLE) || gap_done);
  assign run       = (state != ST_IDLE);
  assign last_bit  = (bitcnt == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      bitcnt <= '0;
      len_q  <= 6'd8;
      cpol_q <= 1'b0;
      shreg  <= '0;
      sdo    <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= cfg_cpol;
    end else if (pkt_start) begin
      cs_n   <= 1'b0;
      len_q  <= len_now;
      cpol_q <= cfg_cpol;
      phase  <= 1'b0;
      if (cfg_dly) begin
        state  <= ST_LEAD;
        shreg  <= frame;
        sdo    <= 1'b0;
        sclk   <= cfg_cpol;
        bitcnt <= '0;
      end else begin
        state  <= ST_BIT;
        shreg  <= frame << 1;
        sdo    <= frame[WORD_W-1];
        sclk   <= !cfg_cpol;
        bitcnt <= 6'd1;
      end
    end else begin
      case (state)
        ST_IDLE: begin
          sclk <= cfg_cpol;
          sdo  <= 1'b0;
          cs_n <= 1'b1;
        end
        ST_LEAD: begin
          if (half_tick) begin
            if (!phase) phase <= 1'b1;
            else begin
              phase  <= 1'b0;
              state  <= ST_BIT;
              sclk   <= !cpol_q;
              sdo    <= shreg[WORD_W-1];
              shreg  <= shreg << 1;
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_BIT: begin
          if (half_tick) begin
            if (!phase) begin
              phase <= 1'b1;
              sclk  <= cpol_q;
            end else if (last_bit) begin
              phase <= 1'b0;
              state <= ST_GAP;
              cs_n  <= 1'b1;
              sdo   <= 1'b0;
            end else begin
              phase  <= 1'b0;
              sclk   <= !cpol_q;
              sdo    <= shreg[WORD_W-1];
              shreg  <= shreg << 1;
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: begin
          sclk <= cfg_cpol;
          if (half_tick) begin
            if (!phase) phase <= 1'b1;
            else begin
              phase <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fsync_spi_tx.sv
module fsync_spi_tx #(
  parameter int CLK_DIV = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [2:0]  cfg_len,
  input  logic        cfg_lsb_first,
  input  logic        cfg_cpol,
  input  logic        cfg_dly,
  input  logic        ovr_clr,
  output logic        sclk,
  output logic        sdo,
  output logic        cs_n,
  output logic        tx_ready,
  output logic        overrun
);
  import fstx_pkg::*;
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic [WORD_W-1:0] hold_data;
  logic              hold_full;
  logic              pkt_start;
  logic              run;
  logic              half_tick;

  assign tx_ready = !hold_full;

  fstx_hold u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .take(pkt_start), .ovr_clr(ovr_clr),
    .hold_data(hold_data), .hold_full(hold_full), .overrun(overrun)
  );

  fstx_baud #(.HALF(HALF)) u_baud (
    .clk(clk), .rst(rst), .run(run), .half_tick(half_tick)
  );

  fstx_seq u_seq (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
    .cfg_cpol(cfg_cpol), .cfg_dly(cfg_dly), .hold_full(hold_full),
    .hold_data(hold_data), .half_tick(half_tick), .pkt_start(pkt_start),
    .run(run), .sclk(sclk), .sdo(sdo), .cs_n(cs_n)
  );
endmodule

// File: rtl/fsync_spi_tx_chk.sv
module fsync_spi_tx_chk #(
  parameter int CLK_DIV = 10
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic ovr_clr,
  input logic cfg_cpol,
  input logic pkt_start,
  input logic sclk,
  input logic sdo,
  input logic cs_n,
  input logic tx_ready,
  input logic overrun
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic        past_ok;
  logic        sclk_d;
  logic        armed;
  logic [15:0] since;
  logic        tog;

  assign tog = !cs_n && (sclk != sclk_d);

  always_ff @(posedge clk) begin
    past_ok <= 1'b1;
    sclk_d  <= sclk;
    if (rst || cs_n) begin
      armed <= 1'b0;
      since <= '0;
    end else if (tog) begin
      armed <= 1'b1;
      since <= '0;
    end else begin
      since <= since + 1'b1;
    end
  end

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_ready) |=> !tx_ready);
  assert_start_frees_R7: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> (!cs_n && tx_ready));
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tx_ready) |=> overrun);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cs_n && $past(cs_n)) |-> (sclk == $past(cfg_cpol)));
  assert_sdo_launch_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (!cs_n && $past(!cs_n) && !$stable(sdo)) |-> !$stable(sclk));
  assert_half_period_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (tog && armed) |-> (since == 16'(HALF - 1)));
  assert_reset_state_R10: assert property (@(posedge clk)
    (past_ok && $past(rst)) |-> (cs_n && tx_ready && !overrun && !sdo));
endmodule

bind fsync_spi_tx fsync_spi_tx_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .ovr_clr(ovr_clr), .cfg_cpol(cfg_cpol),
  .pkt_start(pkt_start), .sclk(sclk), .sdo(sdo), .cs_n(cs_n),
  .tx_ready(tx_ready), .overrun(overrun)
);

// File: tb/fsync_spi_tx_tb_top.sv
module fsync_spi_tx_tb_top;
  localparam int DIV  = 10;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0]  cfg_len = '0;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_cpol = 1'b0;
  logic        cfg_dly = 1'b0;
  logic        ovr_clr = 1'b0;
  logic        sclk, sdo, cs_n, tx_ready, overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fsync_spi_tx #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cfg_len(cfg_len),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol), .cfg_dly(cfg_dly),
    .ovr_clr(ovr_clr), .sclk(sclk), .sdo(sdo), .cs_n(cs_n),
    .tx_ready(tx_ready), .overrun(overrun)
  );

  always #4 clk = ~clk;

  logic mon_cpol = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mon_cpol <= cfg_cpol;
  end

  // slave-side monitor with per-packet history
  logic [31:0] h_rx [256];
  int h_nb [256], h_fall [256], h_first [256], h_rise [256];
  int pc = 0;
  logic [31:0] m_rx;
  int m_nb, m_fall, m_first, m_last_tog;
  int m_bad_idle = 0, m_bad_half = 0;
  logic m_prev_cs = 1'b1, m_prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      m_prev_cs = 1'b1;
      m_prev_sclk = sclk;
    end else begin
      if (m_prev_cs && !cs_n) begin
        m_fall = cyc; m_rx = '0; m_nb = 0; m_first = -1; m_last_tog = -1;
      end
      if (!cs_n && sclk !== m_prev_sclk) begin
        if (m_last_tog >= 0 && (cyc - m_last_tog) != HALF) m_bad_half++;
        m_last_tog = cyc;
        if (sclk != mon_cpol) begin
          if (m_first < 0) m_first = cyc;
        end else begin
          m_rx = {m_rx[30:0], sdo};
          m_nb++;
        end
      end
      if (cs_n && sclk !== mon_cpol) m_bad_idle++;
      if (!m_prev_cs && cs_n) begin
        h_rx[pc] = m_rx; h_nb[pc] = m_nb; h_fall[pc] = m_fall;
        h_first[pc] = m_first; h_rise[pc] = cyc; pc++;
      end
      m_prev_cs = cs_n;
      m_prev_sclk = sclk;
    end
  end

  function automatic int exp_len(input logic [2:0] code);
    if (code >= 3'd5) return 32;
    return 8 + 4 * int'(code);
  endfunction

  function automatic logic [31:0] exp_rx(input logic [31:0] d, input logic [2:0] code,
                                         input logic lsb);
    logic [31:0] r;
    int n;
    n = exp_len(code);
    r = '0;
    if (lsb && code == 3'd0) begin
      for (int i = 0; i < 8; i++) r[7-i] = d[i];
    end else begin
      for (int i = 0; i < n; i++) r[i] = d[i];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] code, input logic lsb, input logic dly,
                         input logic cpol);
    while (!(cs_n && tx_ready)) @(negedge clk);
    @(negedge clk);
    cfg_len = code; cfg_lsb_first = lsb; cfg_dly = dly; cfg_cpol = cpol;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_pkts(input int target);
    int guard;
    guard = 0;
    while (pc < target && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic verify_pkt(input int k, input logic [31:0] d, input logic [2:0] code,
                            input logic lsb, input logic dly);
    int n, lead;
    n = exp_len(code);
    lead = dly ? DIV : 0;
    chk(h_nb[k] == n, "R1 bit count", h_nb[k], n);
    chk(h_rx[k] == exp_rx(d, code, lsb), "R2 word order", h_rx[k], exp_rx(d, code, lsb));
    chk(h_first[k] - h_fall[k] == lead, "R4 data delay", h_first[k] - h_fall[k], lead);
    chk(h_rise[k] - h_fall[k] == lead + n * DIV, "R3 select span",
        h_rise[k] - h_fall[k], lead + n * DIV);
  endtask

  task automatic run_pkt(input logic [31:0] d, input logic [2:0] code, input logic lsb,
                         input logic dly, input logic cpol);
    int n0;
    set_cfg(code, lsb, dly, cpol);
    n0 = pc;
    do_write(d);
    wait_pkts(n0 + 1);
    chk(pc == n0 + 1, "R1 packet seen", pc, n0 + 1);
    verify_pkt(n0, d, code, lsb, dly);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(cs_n == 1'b1, "R10 cs_n", cs_n, 1);
    chk(tx_ready == 1'b1, "R10 ready", tx_ready, 1);
    chk(overrun == 1'b0, "R10 overrun", overrun, 0);
    chk(sclk == cfg_cpol && sdo == 1'b0, "R10 sclk/sdo", {sclk, sdo}, {cfg_cpol, 1'b0});

    // R7 write-to-select latency, then an idle-high 8-bit packet with lead
    set_cfg(3'd0, 1'b0, 1'b1, 1'b1);
    n0 = pc;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_00A5;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tx_ready == 1'b0 && cs_n == 1'b1, "R7 after write", {tx_ready, cs_n}, 2'b01);
    @(negedge clk);
    chk(cs_n == 1'b0 && tx_ready == 1'b1, "R7 at start", {cs_n, tx_ready}, 2'b01);
    wait_pkts(n0 + 1);
    verify_pkt(n0, 32'h0000_00A5, 3'd0, 1'b0, 1'b1);

    // R2 lsb-first 8-bit, and lsb request ignored on 16-bit
    run_pkt(32'h0000_0013, 3'd0, 1'b1, 1'b0, 1'b0);
    run_pkt(32'h0000_8001, 3'd2, 1'b1, 1'b1, 1'b1);

    // R1 every length code, directed
    for (int c = 0; c < 8; c++) run_pkt(32'hC3A5_5A3C ^ c, 3'(c), 1'b0, c[0], c[1]);

    // random mix of length, order, delay and polarity
    for (int i = 0; i < 20; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_pkt($urandom, r[2:0], r[3], r[4], r[5]);
    end

    // R8 back-to-back with R9 overrun on a third write
    set_cfg(3'd0, 1'b0, 1'b0, 1'b1);
    n0 = pc;
    do_write(32'h0000_005A);
    while (cs_n) @(negedge clk);
    do_write(32'h0000_00C3);
    chk(tx_ready == 1'b0, "R9 ready low before extra write", tx_ready, 0);
    do_write(32'h0000_00FF);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    wait_pkts(n0 + 2);
    verify_pkt(n0, 32'h0000_005A, 3'd0, 1'b0, 1'b0);
    verify_pkt(n0 + 1, 32'h0000_00C3, 3'd0, 1'b0, 1'b0);
    chk(h_fall[n0+1] - h_rise[n0] == DIV, "R8 gap", h_fall[n0+1] - h_rise[n0], DIV);
    repeat (20 * DIV) @(negedge clk);
    chk(pc == n0 + 2, "R9 dropped write not sent", pc, n0 + 2);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R9 overrun cleared", overrun, 0);

    // R10 reset in the middle of a packet
    set_cfg(3'd5, 1'b0, 1'b0, 1'b0);
    do_write(32'hFFFF_FFFF);
    do_write(32'h1234_5678);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && tx_ready == 1'b1, "R10 mid-packet reset",
        {cs_n, tx_ready}, 2'b11);
    chk(sclk == 1'b0 && sdo == 1'b0, "R10 lines idle", {sclk, sdo}, 2'b00);
    n0 = pc;
    repeat (40 * DIV) @(negedge clk);
    chk(pc == n0, "R10 pending word dropped", pc, n0);

    // accumulated clock-shape checks
    chk(m_bad_idle == 0, "R5 idle level", m_bad_idle, 0);
    chk(m_bad_half == 0, "R6 half period", m_bad_half, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule